// File: doc/BRIEF.md
# Word/Byte Selectable Arithmetic and Logic Unit

This block is the combinational arithmetic and logic stage of a 16-bit processor datapath. It takes a destination operand, a second operand and a 4-bit operation code. The second operand has already been chosen outside the block, either from a register or from an encoded constant. It returns the new destination value, a write-back enable and a set of four status flags. A size select picks one of two widths. In word width all 16 bits take part. In byte width only the low byte is computed, and the upper byte of the destination passes through unchanged.

The block holds no state and has no state machine. Every output is a pure function of the present inputs. The present flag values come in on `flags_i`, so an unrecognised operation code can hand them straight back. The surrounding core then writes `flags_o` into its status word on every operation without any special case. Addition and subtraction run in a full-width adder and a low-byte adder placed side by side. The size select chooses which adder supplies the result and the flags.

Top module: `wbalu_core`

## Requirements
- R1: `op_i` codes are 0000 add, 0001 add with carry, 0010 subtract, 0011 subtract with carry, 0110 exclusive OR, 0111 AND, 1000 bit test, 1001 bit clear and 1010 bit set. Add returns DST + SRC.
- R2: Add with carry returns DST + SRC + `cin_i`. Plain add ignores `cin_i`.
- R3: Subtract returns DST + ~SRC + 1. Subtract with carry returns DST + ~SRC + `cin_i`.
- R4: Exclusive OR returns DST ^ SRC. AND returns DST & SRC. Bit clear returns DST & ~SRC. Bit set returns DST | SRC.
- R5: Bit test sets the flags from DST & SRC. It drives `wr_en_o` low, and `res_o` equals DST.
- R6: With `byte_i`=1 only bits 7..0 are computed, and `res_o[15:8]` equals `dst_i[15:8]`. With `byte_i`=0 all 16 bits are computed.
- R7: Flag vector layout is bit 3 V, bit 2 N, bit 1 Z, bit 0 C. For arithmetic operations C is the carry out of bit 15, or out of bit 7 in byte width.
- R8: For arithmetic operations V is set when the two addend sign bits agree and the sum sign bit differs, taken at the active width. The addends are DST and SRC, or DST and ~SRC for subtraction.
- R9: Z and N are evaluated on the active width only: the low byte in byte width, all 16 bits in word width.
- R10: Exclusive OR, AND, bit test, bit clear and bit set force C and V to 0 whatever `cin_i` is.
- R11: Any other `op_i` code drives `wr_en_o` low, returns `flags_o` equal to `flags_i` and `res_o` equal to DST.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dst_i | input | 16 | Destination operand |
| src_i | input | 16 | Second operand, register or constant already selected |
| cin_i | input | 1 | Carry in from the status word |
| op_i | input | 4 | Operation code |
| byte_i | input | 1 | 1 selects byte width, 0 selects word width |
| flags_i | input | 4 | Present flags {V,N,Z,C} |
| res_o | output | 16 | Value for write-back |
| wr_en_o | output | 1 | Destination write-back enable |
| flags_o | output | 4 | New flags {V,N,Z,C} |

## Verification
The block contains no register, so every result, the write enable and all four flags are due in the same cycle that their inputs are applied. The bench changes inputs only just after a rising clock edge. It compares outputs at the following falling edge, half a period later, when the combinational paths have settled and no process is racing an edge. Hand-worked cases cover each carry, overflow, zero and sign corner. A sweep then compares every code, valid or not, in both widths against a model built from the requirements.

// File: rtl/wbalu_pkg.sv
package wbalu_pkg;

    typedef enum logic [3:0] {
        OP_ADD  = 4'h0,
        OP_ADDC = 4'h1,
        OP_SUB  = 4'h2,
        OP_SUBC = 4'h3,
        OP_XOR  = 4'h6,
        OP_AND  = 4'h7,
        OP_TST  = 4'h8,
        OP_CLR  = 4'h9,
        OP_SET  = 4'hA
    } alu_op_e;

    typedef struct packed {
        logic v;
        logic n;
        logic z;
        logic c;
    } alu_flags_t;

endpackage

// File: rtl/wbalu_adder.sv
module wbalu_adder #(
    parameter int unsigned W = 16
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         inv_i,
    input  logic         ci_i,
    output logic [W-1:0] sum_o,
    output logic         co_o,
    output logic         ov_o
);
    logic [W-1:0] b_eff;
    logic [W:0]   wide;

    always_comb begin
        b_eff = inv_i ? ~b_i : b_i;
        wide  = {1'b0, a_i} + {1'b0, b_eff} + {{W{1'b0}}, ci_i};
        sum_o = wide[W-1:0];
        co_o  = wide[W];
        ov_o  = (a_i[W-1] == b_eff[W-1]) && (wide[W-1] != a_i[W-1]);
    end
endmodule

// File: rtl/wbalu_logic.sv
module wbalu_logic
    import wbalu_pkg::*;
#(
    parameter int unsigned W = 16
) (
    input  logic [3:0]   op_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] y_o
);
    always_comb begin
        unique case (op_i)
            OP_XOR:         y_o = a_i ^ b_i;
            OP_AND, OP_TST: y_o = a_i & b_i;
            OP_CLR:         y_o = a_i & ~b_i;
            OP_SET:         y_o = a_i | b_i;
            default:        y_o = '0;
        endcase
    end
endmodule

// File: rtl/wbalu_core.sv
module wbalu_core
    import wbalu_pkg::*;
#(
    parameter int unsigned W    = 16,
    parameter int unsigned LANE = 8
) (
    input  logic [W-1:0] dst_i,
    input  logic [W-1:0] src_i,
    input  logic         cin_i,
    input  logic [3:0]   op_i,
    input  logic         byte_i,
    input  logic [3:0]   flags_i,
    output logic [W-1:0] res_o,
    output logic         wr_en_o,
    output logic [3:0]   flags_o
);
    localparam int unsigned HI = W - LANE;

    logic         is_arith, is_logic, invert, carry_in;
    logic [W-1:0] sum_w, logic_y, core;
    logic [LANE-1:0] sum_l;
    logic         co_w, ov_w, co_l, ov_l;
    alu_flags_t   fl_new, fl_in;

    always_comb begin
        is_arith = 1'b0;
        is_logic = 1'b0;
        invert   = 1'b0;
        carry_in = 1'b0;
        unique case (op_i)
            OP_ADD:  is_arith = 1'b1;
            OP_ADDC: begin is_arith = 1'b1; carry_in = cin_i; end
            OP_SUB:  begin is_arith = 1'b1; invert = 1'b1; carry_in = 1'b1; end
            OP_SUBC: begin is_arith = 1'b1; invert = 1'b1; carry_in = cin_i; end
            OP_XOR, OP_AND, OP_TST, OP_CLR, OP_SET: is_logic = 1'b1;
            default: ;
        endcase
    end

    wbalu_adder #(.W(W)) u_add_word (
        .a_i(dst_i), .b_i(src_i), .inv_i(invert), .ci_i(carry_in),
        .sum_o(sum_w), .co_o(co_w), .ov_o(ov_w)
    );

    wbalu_adder #(.W(LANE)) u_add_lane (
        .a_i(dst_i[LANE-1:0]), .b_i(src_i[LANE-1:0]), .inv_i(invert), .ci_i(carry_in),
        .sum_o(sum_l), .co_o(co_l), .ov_o(ov_l)
    );

    wbalu_logic #(.W(W)) u_logic (
        .op_i(op_i), .a_i(dst_i), .b_i(src_i), .y_o(logic_y)
    );

    always_comb begin
        fl_in = alu_flags_t'(flags_i);
        if (is_arith)
            core = byte_i ? {{HI{1'b0}}, sum_l} : sum_w;
        else
            core = logic_y;

        fl_new.c = is_arith && (byte_i ? co_l : co_w);
        fl_new.v = is_arith && (byte_i ? ov_l : ov_w);
        fl_new.z = byte_i ? (core[LANE-1:0] == '0) : (core == '0);
        fl_new.n = byte_i ? core[LANE-1] : core[W-1];

        if ((is_arith || is_logic) && (op_i != OP_TST)) begin
            res_o   = byte_i ? {dst_i[W-1:LANE], core[LANE-1:0]} : core;
            wr_en_o = 1'b1;
        end else begin
            res_o   = dst_i;
            wr_en_o = 1'b0;
        end
        flags_o = (is_arith || is_logic) ? fl_new : fl_in;
    end

    always_comb begin
        if (!$isunknown({dst_i, src_i, cin_i, op_i, byte_i, flags_i})) begin
            if (op_i == OP_TST)
                assert_bit_no_write_R5: assert (!wr_en_o && res_o == dst_i);
            if (byte_i)
                assert_high_byte_kept_R6: assert (res_o[W-1:LANE] == dst_i[W-1:LANE]);
            if (is_logic)
                assert_logic_cv_clear_R10: assert (!flags_o[3] && !flags_o[0]);
            if (!is_arith && !is_logic)
                assert_unused_flags_hold_R11: assert (flags_o == flags_i && !wr_en_o);
        end
    end
endmodule

// File: tb/sim_wbalu_core.sv
module sim_wbalu_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] dst = '0, src = '0;
    logic        cin = 1'b0, byt = 1'b0;
    logic [3:0]  op = '0, fin = '0;
    logic [15:0] res;
    logic        we;
    logic [3:0]  fout;
    int n_chk = 0, n_bad = 0;

    always #4 clk = ~clk;

    wbalu_core u0 (
        .dst_i(dst), .src_i(src), .cin_i(cin), .op_i(op), .byte_i(byt),
        .flags_i(fin), .res_o(res), .wr_en_o(we), .flags_o(fout)
    );

    function automatic logic [20:0] model(input logic [15:0] d, s, input logic c,
                                          input logic [3:0] o, input logic b, input logic [3:0] f);
        int w = b ? 8 : 16;
        int mask = b ? 32'hFF : 32'hFFFF;
        int a = int'(d) & mask;
        int x = int'(s) & mask;
        int sum = 0, r = 0, bb = 0;
        logic cc = 0, vv = 0, ar = 0, lg = 0;
        logic [15:0] out;
        case (o)
            4'h0: begin ar = 1; bb = x; sum = a + x; end
            4'h1: begin ar = 1; bb = x; sum = a + x + int'(c); end
            4'h2: begin ar = 1; bb = ~x & mask; sum = a + bb + 1; end
            4'h3: begin ar = 1; bb = ~x & mask; sum = a + bb + int'(c); end
            4'h6: begin lg = 1; r = a ^ x; end
            4'h7, 4'h8: begin lg = 1; r = a & x; end
            4'h9: begin lg = 1; r = a & ~x & mask; end
            4'hA: begin lg = 1; r = a | x; end
            default: ;
        endcase
        if (!ar && !lg) return {1'b0, f, d};
        if (ar) begin
            if (x == 0 && o[1]) bb = mask; // ~0 at width
            r  = sum & mask;
            cc = ((sum >> w) & 1) != 0;
            vv = (((a >> (w-1)) & 1) == ((bb >> (w-1)) & 1)) &&
                 (((r >> (w-1)) & 1) != ((a >> (w-1)) & 1));
        end
        out = b ? {d[15:8], r[7:0]} : r[15:0];
        if (o == 4'h8) return {1'b0, 1'b0, ((r >> (w-1)) & 1) != 0, r == 0, 1'b0, d};
        return {1'b1, vv, ((r >> (w-1)) & 1) != 0, r == 0, cc, out};
    endfunction

    task automatic drive(input logic [15:0] d, s, input logic c, input logic [3:0] o,
                         input logic b, input logic [3:0] f);
        @(posedge clk);
        #1;
        dst = d; src = s; cin = c; op = o; byt = b; fin = f;
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic [20:0] exp);
        n_chk++;
        if ({we, fout, res} !== exp) begin
            n_bad++;
            $display("FAIL %s: got we=%b flags=%b res=%h, expected we=%b flags=%b res=%h",
                     req, we, fout, res, exp[20], exp[19:16], exp[15:0]);
        end
    endtask

    task automatic t_reset;
        drive(16'h0, 16'h0, 1'b0, 4'h0, 1'b0, 4'h0);
        check("R1 idle add of zeros", {1'b1, 4'b0010, 16'h0000});
    endtask

    task automatic t_add;
        drive(16'h1234, 16'h0101, 1'b1, 4'h0, 1'b0, 4'h0);
        check("R1 R2 add ignores carry", {1'b1, 4'b0000, 16'h1335});
        drive(16'h7FFF, 16'h0001, 1'b0, 4'h0, 1'b0, 4'h0);
        check("R8 word signed overflow", {1'b1, 4'b1100, 16'h8000});
        drive(16'hFFFF, 16'h0001, 1'b0, 4'h0, 1'b0, 4'h0);
        check("R7 carry out of bit 15", {1'b1, 4'b0011, 16'h0000});
        drive(16'h0001, 16'h0001, 1'b1, 4'h1, 1'b0, 4'h0);
        check("R2 add with carry", {1'b1, 4'b0000, 16'h0003});
    endtask

    task automatic t_sub;
        drive(16'h0005, 16'h0005, 1'b0, 4'h2, 1'b0, 4'h0);
        check("R3 subtract equal", {1'b1, 4'b0011, 16'h0000});
        drive(16'h0005, 16'h0005, 1'b0, 4'h3, 1'b0, 4'h0);
        check("R3 subtract with carry clear", {1'b1, 4'b0100, 16'hFFFF});
    endtask

    task automatic t_byte;
        drive(16'hAB80, 16'h0080, 1'b0, 4'h0, 1'b1, 4'h0);
        check("R6 R7 R8 byte add carry overflow", {1'b1, 4'b1011, 16'hAB00});
        drive(16'h5500, 16'h7700, 1'b0, 4'h0, 1'b1, 4'h0);
        check("R9 byte zero ignores high byte", {1'b1, 4'b0010, 16'h5500});
        drive(16'h1200, 16'h0081, 1'b0, 4'hA, 1'b1, 4'h0);
        check("R9 byte negative from bit 7", {1'b1, 4'b0100, 16'h1281});
    endtask

    task automatic t_logic;
        drive(16'hAAAA, 16'hAAAA, 1'b1, 4'h6, 1'b0, 4'hF);
        check("R4 R10 xor", {1'b1, 4'b0010, 16'h0000});
        drive(16'h8001, 16'h8000, 1'b1, 4'h7, 1'b0, 4'h0);
        check("R4 and", {1'b1, 4'b0100, 16'h8000});
        drive(16'hFFFF, 16'h00FF, 1'b1, 4'h9, 1'b0, 4'h0);
        check("R4 R10 bit clear", {1'b1, 4'b0100, 16'hFF00});
        drive(16'h00F0, 16'h0F00, 1'b1, 4'h8, 1'b0, 4'hF);
        check("R5 bit test no write", {1'b0, 4'b0010, 16'h00F0});
    endtask

    task automatic t_unused;
        drive(16'h4321, 16'h1111, 1'b1, 4'h4, 1'b0, 4'b1010);
        check("R11 code 0100 holds flags", {1'b0, 4'b1010, 16'h4321});
        drive(16'h4321, 16'h1111, 1'b0, 4'hF, 1'b1, 4'b0101);
        check("R11 code 1111 holds flags", {1'b0, 4'b0101, 16'h4321});
    endtask

    task automatic t_sweep;
        logic [31:0] lf = 32'hACE1_1357;
        for (int k = 0; k < 24; k++) begin
            for (int o = 0; o < 16; o++) begin
                for (int b = 0; b < 2; b++) begin
                    drive(lf[15:0], lf[31:16], lf[3], 4'(o), b[0], lf[7:4]);
                    check("R1 sweep vs model", model(lf[15:0], lf[31:16], lf[3], 4'(o), b[0], lf[7:4]));
                end
            end
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
        end
    endtask

    initial begin
        fork
            begin
                repeat (3) @(posedge clk);
                rst_n = 1'b1;
                t_reset;
                t_add;
                t_sub;
                t_byte;
                t_logic;
                t_unused;
                t_sweep;
            end
            begin
                repeat (100000) @(posedge clk);
                n_chk++;
                n_bad++;
                $display("FAIL watchdog: got timeout, expected completion");
            end
        join_any
        disable fork;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule